// File: doc/BRIEF.md
# First-Level Compressed Bit-Vector Route Lookup

This block resolves the first sixteen levels of an IPv4 longest-prefix-match search. The depth-16 prefix space is held as a compressed bit vector. The block never stores that vector. It keeps three derived tables and a pointer array:

- A code word for each 16-bit slice of the vector. A code word holds a 10-bit shape number and a 6-bit running offset.
- A base index for each group of four slices. It counts the set bits that come before the group.
- A shape table of 4-bit offsets, with one row per shape number and one column per bit of the slice.
- The pointer array.

A destination address flows through a three-stage pipeline and produces a 16-bit pointer. The pointer's top two bits give its kind. Its low fourteen bits index either a next-hop table or a deeper chunk array.

The block takes one address per cycle. Each result appears a fixed number of cycles later, marked by a valid strobe. The tables are filled by the control plane through a single write port, where a select field chooses the target memory. Shape numbers at or above a threshold mark a slice whose pointer position needs no shape-table read. For those slices the shape-table lookup is skipped.

Top module: `bvl_lookup`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid is 0 and out_type and out_index are 0.
- R2: A lookup accepted with in_valid high at clock edge k gives out_valid high in the cycle after edge k+2, which is three edges later. Back-to-back lookups give back-to-back results in order, and a cycle with in_valid low gives a cycle with out_valid low.
- R3: The code word is read at in_addr[31:20]. The base index is read at in_addr[31:22], so four adjacent code words share one base index.
- R4: Let the code word be cw, let r = cw[15:6], and let c = in_addr[19:16]. When r < 677, the pointer position is base + cw[5:0] + shape[r][c].
- R5: When r >= 677, the shape table is not read and the position is base + cw[5:0]. The value r = 676 still uses the shape table.
- R6: For the pointer p read at the position, out_type = p[15:14] and out_index = p[13:0].
- R7: The write port acts when wr_en is high. wr_sel selects the target:
  - 0: code word at wr_addr[11:0].
  - 1: base index at wr_addr[9:0].
  - 2: shape nibble, with row wr_addr[13:4], column wr_addr[3:0] and data wr_data[3:0].
  - 3: pointer at wr_addr[9:0].
  A write at one edge is seen by any lookup whose read of that table happens at a later edge.
- R8: Only the low 10 bits of the 16-bit position address the pointer array (1024 entries), so positions wrap modulo 1024.
- R9: Whenever out_valid is 0, out_type and out_index are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 32 | Destination address |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Target memory: 0 code word, 1 base, 2 shape nibble, 3 pointer |
| wr_addr | input | 16 | Write address within the selected memory |
| wr_data | input | 16 | Write data |
| out_valid | output | 1 | Result strobe |
| out_type | output | 2 | Pointer kind |
| out_index | output | 14 | Next-hop or chunk index |

## Verification
Lookups are run in several groups:
- Two addresses that share a code word but differ in address bits [19:16] show that the shape column is used.
- Addresses in neighbouring code words, inside one base group and across a group boundary, tell the code-word index apart from the base-index index.
- Shape numbers 676, 677 and 700 separate the shape-table path from the direct path at its exact threshold.
- A base near the top of the pointer array checks the wrap.
- A back-to-back stream with a gap checks ordering and latency.
- An overwrite of a pointer followed at once by a lookup checks write visibility.

// File: rtl/bvl_pkg.sv
package bvl_pkg;

    typedef enum logic [1:0] {
        SEL_CODE  = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_SHAPE = 2'd2,
        SEL_PTR   = 2'd3
    } wr_sel_e;

    // Shape numbers at or above this value skip the shape table
    localparam int unsigned DIRECT_MIN = 677;

endpackage

// File: rtl/bvl_sram.sv
module bvl_sram #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/bvl_shape_ram.sv
module bvl_shape_ram #(
    parameter int unsigned ROWS = 677,
    localparam int unsigned AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wrow,
    input  logic [3:0]    wcol,
    input  logic [3:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] rrow,
    output logic [63:0]   rdata
);
    logic [63:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) mem[wrow][{wcol, 2'b00} +: 4] <= wdata;
        if (re) rdata <= mem[rrow];
    end
endmodule

// File: rtl/bvl_lookup.sv
module bvl_lookup
    import bvl_pkg::*;
#(
    parameter int unsigned CW_AW     = 12,
    parameter int unsigned SHAPE_ROWS = 677,
    parameter int unsigned PTR_AW    = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_addr,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_addr,
    input  logic [15:0] wr_data,
    output logic        out_valid,
    output logic [1:0]  out_type,
    output logic [13:0] out_index
);
    localparam int unsigned BASE_AW  = CW_AW - 2;
    localparam int unsigned SHAPE_AW = $clog2(SHAPE_ROWS);

    typedef struct packed {
        logic        s1_v;
        logic [3:0]  s1_col;
        logic        s2_v;
        logic        s2_direct;
        logic [3:0]  s2_col;
        logic [15:0] s2_part;
        logic        s3_v;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [15:0] cw_rd, base_rd, ptr_rd;
    logic [63:0] shape_rd;
    logic [9:0]  shape_num;
    logic        direct;
    logic [3:0]  shape_off;
    logic [15:0] pos;
    logic        s1_valid;

    // table write decode
    logic we_cw, we_base, we_shape, we_ptr;
    always_comb begin
        we_cw    = wr_en && (wr_sel == SEL_CODE);
        we_base  = wr_en && (wr_sel == SEL_BASE);
        we_shape = wr_en && (wr_sel == SEL_SHAPE);
        we_ptr   = wr_en && (wr_sel == SEL_PTR);
    end

    // stage 1 memories: code word and base index
    bvl_sram #(.W(16), .DEPTH(2**CW_AW)) u_code (
        .clk(clk), .we(we_cw), .waddr(wr_addr[CW_AW-1:0]), .wdata(wr_data),
        .re(in_valid), .raddr(in_addr[31 -: CW_AW]), .rdata(cw_rd)
    );

    bvl_sram #(.W(16), .DEPTH(2**BASE_AW)) u_base (
        .clk(clk), .we(we_base), .waddr(wr_addr[BASE_AW-1:0]), .wdata(wr_data),
        .re(in_valid), .raddr(in_addr[31 -: BASE_AW]), .rdata(base_rd)
    );

    // stage 2 memory: shape offsets
    always_comb begin
        shape_num = cw_rd[15:6];
        direct    = (32'(shape_num) >= DIRECT_MIN);
    end

    bvl_shape_ram #(.ROWS(SHAPE_ROWS)) u_shape (
        .clk(clk), .we(we_shape), .wrow(wr_addr[SHAPE_AW+3:4]), .wcol(wr_addr[3:0]),
        .wdata(wr_data[3:0]), .re(st_q.s1_v && !direct),
        .rrow(shape_num[SHAPE_AW-1:0]), .rdata(shape_rd)
    );

    // stage 3 memory: pointer array
    always_comb begin
        shape_off = st_q.s2_direct ? 4'd0 : shape_rd[{st_q.s2_col, 2'b00} +: 4];
        pos       = st_q.s2_part + {12'd0, shape_off};
    end

    bvl_sram #(.W(16), .DEPTH(2**PTR_AW)) u_ptr (
        .clk(clk), .we(we_ptr), .waddr(wr_addr[PTR_AW-1:0]), .wdata(wr_data),
        .re(st_q.s2_v), .raddr(pos[PTR_AW-1:0]), .rdata(ptr_rd)
    );

    // next-state computation
    always_comb begin
        st_d           = st_q;
        st_d.s1_v      = in_valid;
        st_d.s1_col    = in_addr[19:16];
        st_d.s2_v      = st_q.s1_v;
        st_d.s2_direct = direct;
        st_d.s2_col    = st_q.s1_col;
        st_d.s2_part   = base_rd + {10'd0, cw_rd[5:0]};
        st_d.s3_v      = st_q.s2_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        s1_valid  = st_q.s1_v;
        out_valid = st_q.s3_v;
        out_type  = st_q.s3_v ? ptr_rd[15:14] : 2'd0;
        out_index = st_q.s3_v ? ptr_rd[13:0]  : 14'd0;
    end

    logic unused_ok;
    assign unused_ok = ^{wr_addr, wr_data, pos};
endmodule

// File: rtl/bvl_lookup_chk.sv
module bvl_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        s1_valid,
    input logic        out_valid,
    input logic [1:0]  out_type,
    input logic [13:0] out_index
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
    end

    // R1: result strobe is low just after reset
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2: first stage follows the request one edge later
    p_stage_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) |-> (s1_valid == $past(in_valid)));

    // R2: result strobe is the request strobe three edges later
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R9: fields read zero while no result is presented
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_type == 2'd0 && out_index == 14'd0));
endmodule

bind bvl_lookup bvl_lookup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .s1_valid(s1_valid),
    .out_valid(out_valid), .out_type(out_type), .out_index(out_index)
);

// File: tb/tb_bvl_lookup.sv
module tb_bvl_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        out_valid;
    logic [1:0]  out_type;
    logic [13:0] out_index;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bvl_lookup dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_type(out_type), .out_index(out_index)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] cw(input int r, input int off);
        return 16'((r << 6) | off);
    endfunction

    // one lookup, result compared as {valid, type, index}
    task automatic look(input string req, input logic [31:0] a, input logic [15:0] ptr);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(req, {15'd0, out_valid, 16'd0}, 32'd0);
        @(negedge clk);
        check(req, {15'd0, out_valid, out_type, out_index}, {15'd0, 1'b1, ptr});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 fields", {16'd0, out_type, out_index}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {15'd0, out_valid, out_type, out_index}, 32'd0);
    endtask

    task automatic t_fill;
        wr(2'd0, 16'h123, cw(5, 3));
        wr(2'd0, 16'h120, cw(6, 0));
        wr(2'd0, 16'h124, cw(6, 1));
        wr(2'd1, 16'h048, 16'd100);
        wr(2'd1, 16'h049, 16'd200);
        wr(2'd2, 16'((5 << 4) | 4), 16'd7);
        wr(2'd2, 16'((5 << 4) | 15), 16'd9);
        wr(2'd2, 16'((6 << 4) | 0), 16'd2);
        wr(2'd3, 16'd110, 16'hAABC);
        wr(2'd3, 16'd112, 16'h4321);
        wr(2'd3, 16'd102, 16'hC005);
        wr(2'd3, 16'd203, 16'h0077);
        // direct threshold: code words in base group 0x80
        wr(2'd0, 16'h200, cw(700, 10));
        wr(2'd0, 16'h201, cw(676, 0));
        wr(2'd0, 16'h202, cw(677, 2));
        wr(2'd1, 16'h080, 16'd50);
        wr(2'd2, 16'((676 << 4) | 3), 16'd5);
        wr(2'd3, 16'd60, 16'h1111);
        wr(2'd3, 16'd55, 16'h2222);
        wr(2'd3, 16'd52, 16'h3333);
        // wrap case
        wr(2'd0, 16'h240, cw(0, 10));
        wr(2'd1, 16'h090, 16'd1020);
        wr(2'd2, 16'h0000, 16'd0);
        wr(2'd3, 16'd6, 16'h5A5A);
    endtask

    task automatic t_shape_path;
        look("R4 R6 col4", 32'h1234_5678, 16'hAABC);
        look("R4 R6 col15", 32'h123F_0000, 16'h4321);
    endtask

    task automatic t_index_split;
        look("R3 same group", 32'h1200_0000, 16'hC005);
        look("R3 next group", 32'h1240_0000, 16'h0077);
    endtask

    task automatic t_direct;
        look("R5 r700 direct", 32'h2003_0000, 16'h1111);
        look("R5 r676 uses shape", 32'h2013_0000, 16'h2222);
        look("R5 r677 direct", 32'h2023_0000, 16'h3333);
    endtask

    task automatic t_wrap;
        look("R8 wrap", 32'h2400_0000, 16'h5A5A);
    endtask

    task automatic t_stream;
        logic [31:0] a [5];
        logic [16:0] e [5];
        a[0] = 32'h1234_5678; e[0] = {1'b1, 16'hAABC};
        a[1] = 32'h2023_0000; e[1] = {1'b1, 16'h3333};
        a[2] = 32'h0;         e[2] = 17'd0;
        a[3] = 32'h1240_0000; e[3] = {1'b1, 16'h0077};
        a[4] = 32'h2400_0000; e[4] = {1'b1, 16'h5A5A};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i >= 3)
                check("R2 stream", {15'd0, out_valid, out_type, out_index}, {15'd0, e[i-3]});
            if (i < 5) begin
                in_valid = (i != 2);
                in_addr  = a[i];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_overwrite;
        wr(2'd3, 16'd110, 16'h0001);
        look("R7 new pointer", 32'h1234_5678, 16'h0001);
        wr(2'd2, 16'((5 << 4) | 4), 16'd2);
        wr(2'd3, 16'd105, 16'h8009);
        look("R7 new shape", 32'h1234_5678, 16'h8009);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_shape_path();
        t_index_split();
        t_direct();
        t_wrap();
        t_stream();
        t_overwrite();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule